// File: doc/BRIEF.md
# Prioritized Interrupt Request Resolver

This block keeps a set of pending interrupt requests organised as priority levels, each level holding a vector of independent request bits. It compares what is pending against the processor's current priority. It raises a pending flag whenever at least one request could be taken. When the processor acknowledges, the block chooses the winning request, retires that request bit, and returns the vector number stored for it one cycle later.

Vector numbers come from a writable table indexed by level and bit. The one exception is the software request bit of levels 1 and up, which always answers with one shared vector. A bus-mode select adds a second eligibility rule. In the alternate mode, once the current priority reaches a threshold, only requests flagged as internal may win, and device requests are held back.

Top module: `irq_resolver`

## Requirements
- R1: After reset no request is held, `irq_pending` is 0, `vec_out` is 0, `vec_valid` is 0, and every vector table entry reads 0.
- R2: A request is only eligible when its level is strictly greater than `cur_pri`. `irq_pending` is the combinational OR of all eligible requests for the present `cur_pri` and `alt_bus`.
- R3: When several levels hold eligible requests, the highest level wins.
- R4: An `int_ack` with an eligible request clears the winning request bit. In the next cycle it shows `vec_valid`=1 and `vec_out` equal to that entry's vector. Without `int_ack`, `vec_valid` is 0 and `vec_out` holds its value.
- R5: An `int_ack` with no eligible request shows `vec_out`=0 and `vec_valid`=0 in the next cycle and leaves every request unchanged.
- R6: Within the winning level, the eligible bit with the lowest index wins.
- R7: With `alt_bus`=1 and `cur_pri` >= `ALT_THRESH` (default 4), only the internal bits are eligible: bit 0 and bit `SOFT_BIT` (31) by default. With `alt_bus`=0, or below the threshold, every bit is eligible.
- R8: A grant of bit `SOFT_BIT` at any level from 1 upward returns `SOFT_VEC` (default 160), whatever the table holds for that entry.
- R9: A request strobe raised for a bit in the same cycle that an acknowledge retires that bit leaves the bit pending.
- R10: `tbl_we` writes `tbl_data` into entry (`tbl_lvl`, `tbl_bit`) at the clock edge. An acknowledge in that same cycle reads the entry's previous content.
- R11: `req_set` bit `l*NBIT+b` sets request bit b of level l. Requests accumulate until they are granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | NLVL*NBIT | Request set strobes, bit l*NBIT+b targets level l bit b |
| cur_pri | input | $clog2(NLVL) | Current processor priority |
| alt_bus | input | 1 | Selects the alternate bus mode with threshold masking |
| int_ack | input | 1 | Acknowledge strobe |
| tbl_we | input | 1 | Vector table write enable |
| tbl_lvl | input | $clog2(NLVL) | Table write level |
| tbl_bit | input | $clog2(NBIT) | Table write bit index |
| tbl_data | input | VW | Table write data |
| irq_pending | output | 1 | An eligible request exists |
| vec_out | output | VW | Vector of the last acknowledge |
| vec_valid | output | 1 | Last acknowledge granted a request |

## Verification
The bench builds the block with its default parameters: 8 levels of 32 bits, 9-bit vectors, threshold 4 and the software bit at 31. With these values the full table of 256 entries can be written and read back through grants in a short run. Every priority level, including the unreachable level 0 and the fully masked priority 7, comes up under random `cur_pri`. Both internal bits lie at the two ends of a level, which exercises the lowest-index rule against the threshold mask.

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int NLVL = 8,
  parameter int NBIT = 32,
  parameter int VW = 9,
  parameter int ALT_THRESH = 4,
  parameter int SOFT_BIT = NBIT - 1,
  parameter logic [VW-1:0] SOFT_VEC = VW'(160),
  parameter logic [NBIT-1:0] INT_MASK = NBIT'(1),
  localparam int LW = $clog2(NLVL),
  localparam int BW = $clog2(NBIT),
  localparam int NENT = NLVL * NBIT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NLVL*NBIT-1:0] req_set,
  input  logic [LW-1:0]        cur_pri,
  input  logic                 alt_bus,
  input  logic                 int_ack,
  input  logic                 tbl_we,
  input  logic [LW-1:0]        tbl_lvl,
  input  logic [BW-1:0]        tbl_bit,
  input  logic [VW-1:0]        tbl_data,
  output logic                 irq_pending,
  output logic [VW-1:0]        vec_out,
  output logic                 vec_valid
);

  localparam logic [NBIT-1:0] INTERNAL = INT_MASK | (NBIT'(1) << SOFT_BIT);

  logic [NLVL-1:0][NBIT-1:0] req_q, set_v, elig, clr;
  logic [VW-1:0] tbl_q [NENT];
  logic          restrict_on, found;
  logic [LW-1:0] win_l;
  logic [BW-1:0] win_b;
  logic [VW-1:0] win_vec;

  assign set_v = req_set;
  assign restrict_on = alt_bus && (int'(cur_pri) >= ALT_THRESH);

  always_comb begin
    for (int l = 0; l < NLVL; l++)
      elig[l] = (l > int'(cur_pri)) ? (req_q[l] & (restrict_on ? INTERNAL : '1)) : '0;
  end

  always_comb begin
    found = 1'b0;
    win_l = '0;
    win_b = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (|elig[l]) begin
        found = 1'b1;
        win_l = LW'(l);
        for (int b = NBIT - 1; b >= 0; b--)
          if (elig[l][b]) win_b = BW'(b);
      end
    end
  end

  assign irq_pending = found;
  assign win_vec = (int'(win_b) == SOFT_BIT && win_l != '0) ? SOFT_VEC : tbl_q[{win_l, win_b}];

  always_comb begin
    clr = '0;
    if (int_ack && found) clr[win_l][win_b] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      vec_out <= '0;
      vec_valid <= 1'b0;
    end else begin
      req_q <= (req_q & ~clr) | set_v;
      vec_valid <= int_ack && found;
      if (int_ack) vec_out <= found ? win_vec : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) tbl_q[i] <= '0;
    end else if (tbl_we) begin
      tbl_q[{tbl_lvl, tbl_bit}] <= tbl_data;
    end
  end

endmodule

module irq_resolver_chk #(
  parameter int NLVL = 8,
  parameter int VW = 9,
  localparam int LW = $clog2(NLVL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] cur_pri,
  input logic          int_ack,
  input logic          irq_pending,
  input logic [VW-1:0] vec_out,
  input logic          vec_valid
);
  AST_TOP_PRI_MASKS: assert property (@(posedge clk) disable iff (!rst_n) (cur_pri == LW'(NLVL - 1)) |-> !irq_pending); // R2
  AST_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n) (int_ack && irq_pending) |=> vec_valid); // R4
  AST_NO_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !int_ack |=> (!vec_valid && $stable(vec_out))); // R4
  AST_EMPTY_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (int_ack && !irq_pending) |=> (!vec_valid && vec_out == '0)); // R5
  AST_RESET_CLEAN: assert property (@(posedge clk) $fell(rst_n) |=> (!vec_valid && vec_out == '0)); // R1
endmodule

bind irq_resolver irq_resolver_chk #(.NLVL(NLVL), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cur_pri(cur_pri), .int_ack(int_ack),
  .irq_pending(irq_pending), .vec_out(vec_out), .vec_valid(vec_valid)
);

// File: tb/irq_resolver_tb_top.sv
module irq_resolver_tb_top;
  localparam int NL = 8, NB = 32, VW = 9, TH = 4, SB = 31;
  localparam logic [VW-1:0] SV = 9'd160;
  localparam logic [NB-1:0] INTM = 32'h8000_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL*NB-1:0] req_set = '0;
  logic [2:0] cur_pri = '0;
  logic alt_bus = 1'b0, int_ack = 1'b0, tbl_we = 1'b0;
  logic [2:0] tbl_lvl = '0;
  logic [4:0] tbl_bit = '0;
  logic [VW-1:0] tbl_data = '0;
  logic irq_pending, vec_valid;
  logic [VW-1:0] vec_out;

  int checks = 0, errors = 0;
  logic [NB-1:0] req_m [NL];
  logic [VW-1:0] tbl_m [NL][NB];

  always #4 clk = ~clk;

  irq_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .cur_pri(cur_pri), .alt_bus(alt_bus),
    .int_ack(int_ack), .tbl_we(tbl_we), .tbl_lvl(tbl_lvl), .tbl_bit(tbl_bit),
    .tbl_data(tbl_data), .irq_pending(irq_pending), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] elig_of(int l);
    logic [NB-1:0] m;
    if (l <= int'(cur_pri)) return '0;
    m = (alt_bus && cur_pri >= 3'(TH)) ? INTM : '1;
    return req_m[l] & m;
  endfunction

  task automatic pick(output logic f, output int wl, output int wb);
    f = 0; wl = 0; wb = 0;
    for (int l = NL - 1; l >= 0 && !f; l--) begin
      logic [NB-1:0] e;
      e = elig_of(l);
      for (int b = 0; b < NB && !f; b++)
        if (e[b]) begin f = 1; wl = l; wb = b; end
    end
  endtask

  task automatic step(string tag);
    logic f, ack;
    int wl, wb;
    logic [VW-1:0] ev;
    #1;
    pick(f, wl, wb);
    chk({tag, " pending"}, 32'(irq_pending), 32'(f));
    ack = int_ack;
    ev = !f ? '0 : ((wb == SB && wl != 0) ? SV : tbl_m[wl][wb]);
    if (ack && f) req_m[wl][wb] = 1'b0;
    for (int l = 0; l < NL; l++) req_m[l] = req_m[l] | req_set[l*NB +: NB];
    if (tbl_we) tbl_m[tbl_lvl][tbl_bit] = tbl_data;
    @(posedge clk);
    @(negedge clk);
    if (ack) begin
      chk({tag, " vec_valid"}, 32'(vec_valid), 32'(f));
      chk({tag, " vec_out"}, 32'(vec_out), 32'(ev));
    end else begin
      chk({tag, " idle valid"}, 32'(vec_valid), 0);
    end
    req_set = '0; int_ack = 0; tbl_we = 0;
  endtask

  task automatic raise(int l, int b);
    req_set[l*NB + b] = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < NL; l++) begin
      req_m[l] = '0;
      for (int b = 0; b < NB; b++) tbl_m[l][b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 pending", 32'(irq_pending), 0);
    chk("R1 vec_out", 32'(vec_out), 0);
    chk("R1 vec_valid", 32'(vec_valid), 0);
    // R1: table reads zero after reset
    raise(5, 7); step("R11 set");
    int_ack = 1; step("R1 zero table");
    // R10: program every entry
    for (int l = 0; l < NL; l++)
      for (int b = 0; b < NB; b++) begin
        tbl_we = 1; tbl_lvl = 3'(l); tbl_bit = 5'(b);
        tbl_data = VW'(l * 37 + b * 3 + 1);
        step("R10 write");
      end
    // R3 and R6: level order and lowest bit
    cur_pri = 3'd2;
    raise(3, 5); raise(3, 2); raise(6, 9); step("R11 accumulate");
    int_ack = 1; step("R3 highest level");
    int_ack = 1; step("R6 lowest bit");
    int_ack = 1; step("R6 next bit");
    int_ack = 1; step("R5 empty ack");
    // R2: level equal to priority is not eligible
    raise(2, 4); step("R2 equal level");
    cur_pri = 3'd1; step("R2 above level");
    cur_pri = 3'd7; int_ack = 1; step("R5 masked ack");
    cur_pri = 3'd1; int_ack = 1; step("R2 grant");
    // R7: alternate bus mode threshold
    alt_bus = 1; cur_pri = 3'd5;
    raise(6, 4); step("R7 device masked");
    raise(6, 0); int_ack = 1; step("R7 internal only");
    int_ack = 1; step("R7 masked ack");
    cur_pri = 3'd3; step("R7 below threshold");
    alt_bus = 0; cur_pri = 3'd5; int_ack = 1; step("R7 normal mode");
    // R8: software bit uses shared vector
    raise(4, SB); cur_pri = 3'd0; int_ack = 1; step("R8 soft vector");
    raise(7, SB); alt_bus = 1; cur_pri = 3'd6; int_ack = 1; step("R8 soft vector alt");
    alt_bus = 0;
    // R9: set and clear of the same bit
    cur_pri = 3'd0; raise(2, 11); step("R9 setup");
    raise(2, 11); int_ack = 1; step("R9 set wins");
    int_ack = 1; step("R9 still pending");
    // R10: write and ack same entry same cycle
    raise(5, 3); step("R10 setup");
    tbl_we = 1; tbl_lvl = 3'd5; tbl_bit = 5'd3; tbl_data = 9'd77; int_ack = 1;
    step("R10 old value");
    raise(5, 3); step("R10 setup2");
    int_ack = 1; step("R10 new value");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int n;
      n = $urandom_range(0, 2);
      for (int k = 0; k < n; k++) begin
        int b;
        b = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 0) ? 0 : SB) : $urandom_range(0, NB - 1);
        raise($urandom_range(0, NL - 1), b);
      end
      cur_pri = 3'($urandom_range(0, NL - 1));
      alt_bus = 1'($urandom_range(0, 1));
      int_ack = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 9) == 0) begin
        tbl_we = 1; tbl_lvl = 3'($urandom); tbl_bit = 5'($urandom); tbl_data = VW'($urandom);
      end
      step("R2 R3 R4 R6 R7 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule